// File: doc/BRIEF.md
# Pulse Width Measurement Timer

This block times an external digital pulse. A count-clock strobe, produced by a prescaler elsewhere, advances an internal counter while a measurement is open. The measurement opens and closes on edges of the pulse input chosen by a 3-bit mode code. The available modes are the high phase, the low phase, a full period taken between rising edges, a full period taken between falling edges, and a combined mode. The combined mode reports both the high phase and the rising-edge period of each cycle of the input.

At every closing edge the running count is copied to the width output, and a valid flag rises for one cycle. If the counter wraps before a measurement closes, a sticky overflow flag is raised, and it stays set until the clear input is pulsed. Dropping the enable input halts the measurement and discards any edge that was waiting. The pulse input is expected to be synchronous to the clock already.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, widthOut is 0, and widthValid and overflowFlag are both low.
- R2: Mode code 000 (high phase) opens on a rising edge of pulseIn and closes on the next falling edge. After closing it waits for another rising edge.
- R3: Mode code 010 (low phase) opens on a falling edge and closes on the next rising edge.
- R4: Mode code 011 measures from one rising edge to the next, and mode code 100 from one falling edge to the next. In both modes the closing edge also opens the following measurement, with the count restarted from 0.
- R5: Mode code 001 (combined) opens only on a rising edge, even if pulseIn is already high when enable rises. A falling edge captures the count and counting continues. A rising edge captures the count and restarts it from 0.
- R6: Mode codes 101, 110 and 111 behave exactly like 000.
- R7: modeSel is sampled in the first enabled cycle that follows a disabled cycle. Changes to modeSel while enable stays high have no effect.
- R8: A capture made at a clock edge appears on widthOut after that edge, with widthValid high for exactly that one cycle. widthOut holds its value at all other times.
- R9: A count strobe that arrives with the counter at its all-ones value wraps the counter to 0 and sets overflowFlag. overflowClr clears the flag, but a wrap in the same cycle takes priority.
- R10: While enable is low, no capture occurs. When enable returns, the block waits for a fresh opening edge; it does not resume the earlier measurement.
- R11: A measurement counts the tickEn strobes that fall strictly between its opening edge cycle and its closing edge cycle. A strobe in either of those edge cycles is not counted. The exception is the falling-edge cycle of mode 001, which counts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run control; low stops and disarms |
| modeSel | input | 3 | Edge-pair mode code |
| pulseIn | input | 1 | Synchronized pulse being measured |
| tickEn | input | 1 | Count-clock strobe |
| overflowClr | input | 1 | Clears the overflow flag |
| widthOut | output | CNT_W | Last captured count |
| widthValid | output | 1 | One-cycle capture strobe |
| overflowFlag | output | 1 | Sticky counter-wrap flag |

## Verification
The bench builds the timer with CNT_W set to 6. With that width the counter wraps after 64 strobes, so wrap, wrap-then-capture and overflow clear-versus-set priority can be reached in a few hundred cycles, and long random pulses still reach them. Directed sequences cover enabling the combined mode while the input is high, edge-cycle strobes and mode changes during a run. After them comes a long random mix of all eight mode codes, pulse lengths, strobes and enable toggles.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

  typedef enum logic [2:0] {
    MODE_HIGH = 3'b000,
    MODE_BOTH = 3'b001,
    MODE_LOW  = 3'b010,
    MODE_RISE = 3'b011,
    MODE_FALL = 3'b100
  } pwMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_COUNT = 2'd2
  } pwState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic incCnt;
    logic capture;
  } pwStrobe_t;

  // Undefined codes fall back to the high-phase mode
  function automatic pwMode_e decodeMode(input logic [2:0] code);
    case (code)
      3'b001:  return MODE_BOTH;
      3'b010:  return MODE_LOW;
      3'b011:  return MODE_RISE;
      3'b100:  return MODE_FALL;
      default: return MODE_HIGH;
    endcase
  endfunction

endpackage

// File: rtl/pwt_edge_det.sv
module pwt_edge_det (
  input  logic clk,
  input  logic rstN,
  input  logic sigIn,
  output logic riseEdge,
  output logic fallEdge
);
  logic prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= sigIn;
  end

  assign riseEdge = sigIn & ~prevQ;
  assign fallEdge = ~sigIn & prevQ;
endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
  import pwt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic [2:0] modeSel,
  input  logic      riseEdge,
  input  logic      fallEdge,
  input  logic      tickEn,
  output pwStrobe_t strobe
);
  pwState_e stateQ, stateD;
  pwMode_e  modeQ, modeD;

  logic openHit, closeHit, restartCnt, keepRunning;

  // Which edges open and close a measurement in the latched mode
  always_comb begin
    openHit     = 1'b0;
    closeHit    = 1'b0;
    restartCnt  = 1'b0;
    keepRunning = 1'b0;
    case (modeQ)
      MODE_LOW: begin
        openHit  = fallEdge;
        closeHit = riseEdge;
      end
      MODE_RISE: begin
        openHit     = riseEdge;
        closeHit    = riseEdge;
        restartCnt  = 1'b1;
        keepRunning = 1'b1;
      end
      MODE_FALL: begin
        openHit     = fallEdge;
        closeHit    = fallEdge;
        restartCnt  = 1'b1;
        keepRunning = 1'b1;
      end
      MODE_BOTH: begin
        openHit     = riseEdge;
        closeHit    = riseEdge | fallEdge;
        restartCnt  = riseEdge;
        keepRunning = 1'b1;
      end
      default: begin
        openHit  = riseEdge;
        closeHit = fallEdge;
      end
    endcase
  end

  always_comb begin
    stateD = stateQ;
    modeD  = modeQ;
    strobe = '0;
    if (!enable) begin
      stateD = ST_IDLE;
    end else begin
      case (stateQ)
        ST_IDLE: begin
          stateD = ST_ARM;
          modeD  = decodeMode(modeSel);
        end
        ST_ARM: begin
          if (openHit) begin
            strobe.clrCnt = 1'b1;
            stateD        = ST_COUNT;
          end
        end
        ST_COUNT: begin
          if (closeHit) begin
            strobe.capture = 1'b1;
            if (restartCnt)       strobe.clrCnt = 1'b1;
            else if (keepRunning) strobe.incCnt = tickEn;
            else                  stateD        = ST_ARM;
          end else begin
            strobe.incCnt = tickEn;
          end
        end
        default: stateD = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      modeQ  <= MODE_HIGH;
    end else begin
      stateQ <= stateD;
      modeQ  <= modeD;
    end
  end
endmodule

// File: rtl/pwt_datapath.sv
module pwt_datapath
  import pwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwStrobe_t        strobe,
  input  logic             overflowClr,
  output logic [CNT_W-1:0] widthOut,
  output logic             widthValid,
  output logic             overflowFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ;
  logic             wrapHit;

  assign wrapHit = strobe.incCnt && (cntQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.clrCnt) cntQ <= '0;
    else if (strobe.incCnt) cntQ <= cntQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthOut   <= '0;
      widthValid <= 1'b0;
    end else begin
      widthValid <= strobe.capture;
      if (strobe.capture) widthOut <= cntQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            overflowFlag <= 1'b0;
    else if (wrapHit)     overflowFlag <= 1'b1;
    else if (overflowClr) overflowFlag <= 1'b0;
  end
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer
  import pwt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [2:0]       modeSel,
  input  logic             pulseIn,
  input  logic             tickEn,
  input  logic             overflowClr,
  output logic [CNT_W-1:0] widthOut,
  output logic             widthValid,
  output logic             overflowFlag
);
  logic      riseEdge, fallEdge;
  pwStrobe_t strobe;

  pwt_edge_det u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .sigIn    (pulseIn),
    .riseEdge (riseEdge),
    .fallEdge (fallEdge)
  );

  pwt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .modeSel  (modeSel),
    .riseEdge (riseEdge),
    .fallEdge (fallEdge),
    .tickEn   (tickEn),
    .strobe   (strobe)
  );

  pwt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .overflowClr  (overflowClr),
    .widthOut     (widthOut),
    .widthValid   (widthValid),
    .overflowFlag (overflowFlag)
  );
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             tickEn,
  input logic             overflowClr,
  input logic [CNT_W-1:0] widthOut,
  input logic             widthValid,
  input logic             overflowFlag
);
  // R8: the captured width changes only together with the valid strobe
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (widthOut != $past(widthOut)) |-> widthValid);

  // R10: no capture while disabled
  assert_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !widthValid);

  // R9: flag stays set until cleared
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overflowFlag && !overflowClr) |=> overflowFlag);

  // R9: flag rises only from a counted strobe while running
  assert_wrap_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflowFlag) |-> $past(tickEn && enable));

  // R9: clear without a strobe always lands
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (overflowClr && !tickEn) |=> !overflowFlag);
endmodule

bind pulse_width_timer pwt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .tickEn       (tickEn),
  .overflowClr  (overflowClr),
  .widthOut     (widthOut),
  .widthValid   (widthValid),
  .overflowFlag (overflowFlag)
);

// File: tb/tb_pulse_width_timer.sv
module tb_pulse_width_timer;
  localparam int CW = 6;
  localparam logic [CW-1:0] MAXV = {CW{1'b1}};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [2:0]    modeSel = 3'b000;
  logic          pulseIn = 1'b0;
  logic          tickEn = 1'b0;
  logic          overflowClr = 1'b0;
  logic [CW-1:0] widthOut;
  logic          widthValid;
  logic          overflowFlag;

  pulse_width_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .pulseIn(pulseIn), .tickEn(tickEn), .overflowClr(overflowClr),
    .widthOut(widthOut), .widthValid(widthValid), .overflowFlag(overflowFlag)
  );

  always #4 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  string curTag = "";

  // Reference state, built from the requirements
  logic          mPrev = 1'b0;
  int            mState = 0;      // 0 idle, 1 armed, 2 counting
  logic [2:0]    mMode = 3'b000;
  logic [CW-1:0] mCnt = '0;
  logic          mOv = 1'b0;
  logic [CW-1:0] eWidth = '0;
  logic          eValid = 1'b0;
  string         eTag = "R8";

  function automatic logic [2:0] refMode(input logic [2:0] c);
    return (c > 3'd4) ? 3'd0 : c;
  endfunction

  function automatic string modeTag(input logic [2:0] c);
    case (c)
      3'd1: return "R5";
      3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    string t;
    t = (curTag != "") ? curTag : eTag;
    check(t, int'(widthValid), int'(eValid), "widthValid");
    check(t, int'(widthOut), int'(eWidth), "widthOut");
    check((curTag != "") ? curTag : "R9", int'(overflowFlag), int'(mOv), "overflowFlag");
  endtask

  task automatic modelStep(input logic en, input logic [2:0] code, input logic pin,
                           input logic tick, input logic oclr);
    logic rise, fall, op, cl, rs, kp, clr, inc, cap, wrap;
    rise = pin & ~mPrev;
    fall = ~pin & mPrev;
    op = 0; cl = 0; rs = 0; kp = 0; clr = 0; inc = 0; cap = 0;
    case (mMode)
      3'd1: begin op = rise; cl = rise | fall; rs = rise; kp = 1; end
      3'd2: begin op = fall; cl = rise; end
      3'd3: begin op = rise; cl = rise; rs = 1; kp = 1; end
      3'd4: begin op = fall; cl = fall; rs = 1; kp = 1; end
      default: begin op = rise; cl = fall; end
    endcase
    if (!en) mState = 0;
    else if (mState == 0) begin mState = 1; mMode = refMode(code); end
    else if (mState == 1) begin
      if (op) begin clr = 1; mState = 2; end
    end else begin
      if (cl) begin
        cap = 1;
        if (rs) clr = 1;
        else if (kp) inc = tick;
        else mState = 1;
      end else inc = tick;
    end
    eValid = cap;
    if (cap) begin eWidth = mCnt; eTag = modeTag(mMode); end
    wrap = inc && (mCnt == MAXV);
    if (clr) mCnt = '0;
    else if (inc) mCnt = mCnt + 1'b1;
    if (wrap) mOv = 1'b1;
    else if (oclr) mOv = 1'b0;
    mPrev = pin;
  endtask

  // One cycle: check outputs of the last edge, then drive the next inputs
  task automatic cyc(input logic en, input logic [2:0] code, input logic pin,
                     input logic tick, input logic oclr);
    @(negedge clk);
    compareAll();
    enable = en; modeSel = code; pulseIn = pin; tickEn = tick; overflowClr = oclr;
    modelStep(en, code, pin, tick, oclr);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    curTag = "R1";
    check("R1", int'(widthOut), 0, "widthOut in reset");
    check("R1", int'(widthValid), 0, "widthValid in reset");
    check("R1", int'(overflowFlag), 0, "overflowFlag in reset");
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0);

    // R2 high phase: 4 counted strobes
    curTag = "R2";
    cyc(1, 3'd0, 0, 0, 0);
    cyc(1, 3'd0, 1, 1, 0);            // open
    repeat (4) cyc(1, 3'd0, 1, 1, 0);
    cyc(1, 3'd0, 0, 1, 0);            // close
    cyc(1, 3'd0, 0, 0, 0);
    check("R2", int'(widthOut), 4, "high width literal");

    // R11: strobes in open and close cycles not counted (rise-to-rise)
    curTag = "R11";
    cyc(0, 3'd3, 0, 0, 0);
    cyc(1, 3'd3, 0, 1, 0);
    cyc(1, 3'd3, 1, 1, 0);            // open
    cyc(1, 3'd3, 1, 1, 0);
    cyc(1, 3'd3, 0, 1, 0);
    cyc(1, 3'd3, 0, 1, 0);
    cyc(1, 3'd3, 1, 1, 0);            // close and reopen
    cyc(1, 3'd3, 1, 0, 0);
    check("R11", int'(widthOut), 3, "period literal");
    check("R11", int'(widthValid), 1, "valid after close");

    // R5: enable while input high, first fall ignored
    curTag = "R5";
    cyc(0, 3'd1, 1, 0, 0);
    cyc(1, 3'd1, 1, 1, 0);
    cyc(1, 3'd1, 1, 1, 0);
    cyc(1, 3'd1, 0, 1, 0);            // ignored
    repeat (2) cyc(1, 3'd1, 0, 1, 0);
    cyc(1, 3'd1, 1, 1, 0);            // open
    repeat (4) cyc(1, 3'd1, 1, 1, 0);
    cyc(1, 3'd1, 0, 1, 0);            // capture high, keep counting
    cyc(1, 3'd1, 0, 1, 0);
    check("R5", int'(widthOut), 4, "combined high literal");
    cyc(1, 3'd1, 0, 0, 0);
    cyc(1, 3'd1, 1, 1, 0);            // capture period
    cyc(1, 3'd1, 1, 0, 0);
    check("R5", int'(widthOut), 6, "combined period literal");

    // R7: mode change while enabled ignored (stays high phase)
    curTag = "R7";
    cyc(0, 3'd0, 0, 0, 0);
    cyc(1, 3'd0, 0, 0, 0);
    cyc(1, 3'd3, 1, 1, 0);
    repeat (2) cyc(1, 3'd3, 1, 1, 0);
    cyc(1, 3'd3, 0, 0, 0);
    cyc(1, 3'd3, 0, 0, 0);
    check("R7", int'(widthOut), 2, "latched mode width");

    // R6: reserved code acts as high phase; R3 low phase
    curTag = "R6";
    cyc(0, 3'd6, 0, 0, 0);
    cyc(1, 3'd6, 0, 0, 0);
    cyc(1, 3'd6, 1, 0, 0);
    repeat (5) cyc(1, 3'd6, 1, 1, 0);
    cyc(1, 3'd6, 0, 0, 0);
    cyc(1, 3'd6, 0, 0, 0);
    check("R6", int'(widthOut), 5, "reserved code width");
    curTag = "R3";
    cyc(0, 3'd2, 1, 0, 0);
    cyc(1, 3'd2, 1, 0, 0);
    cyc(1, 3'd2, 0, 0, 0);
    repeat (3) cyc(1, 3'd2, 0, 1, 0);
    cyc(1, 3'd2, 1, 0, 0);
    cyc(1, 3'd2, 1, 0, 0);
    check("R3", int'(widthOut), 3, "low width literal");

    // R9: wrap, then clear
    curTag = "R9";
    cyc(0, 3'd0, 0, 0, 0);
    cyc(1, 3'd0, 0, 0, 0);
    cyc(1, 3'd0, 1, 0, 0);
    repeat (70) cyc(1, 3'd0, 1, 1, 0);
    cyc(1, 3'd0, 0, 0, 0);
    cyc(1, 3'd0, 0, 0, 1);
    check("R9", int'(widthOut), 6, "wrapped width");
    cyc(1, 3'd0, 0, 0, 0);
    check("R9", int'(overflowFlag), 0, "flag cleared");

    // R10: disable mid-measurement, re-enable needs new open edge
    curTag = "R10";
    cyc(1, 3'd0, 1, 0, 0);
    repeat (3) cyc(1, 3'd0, 1, 1, 0);
    cyc(0, 3'd0, 0, 1, 0);            // fall while disabled
    cyc(1, 3'd0, 0, 1, 0);
    cyc(1, 3'd0, 0, 1, 0);
    cyc(1, 3'd0, 0, 0, 0);
    check("R10", int'(widthValid), 0, "no capture after re-enable");

    // Random mix
    curTag = "";
    void'($urandom(32'h1F2E3D4C));
    begin
      logic en, pin;
      logic [2:0] code;
      en = 1; pin = 0; code = 3'd0;
      for (int i = 0; i < 6000; i++) begin
        if (en && ($urandom % 300 == 0)) en = 0;
        else if (!en && ($urandom % 8 == 0)) en = 1;
        if ($urandom % 40 == 0) code = 3'($urandom % 8);
        if ($urandom % 9 == 0) pin = ~pin;
        cyc(en, code, pin, 1'($urandom % 2), 1'($urandom % 50 == 0));
      end
    end
    cyc(0, 0, 0, 0, 0);
    finish();
  end
endmodule